// File: doc/BRIEF.md
# EEPROM Status Register and Write Guard

This block keeps the status byte of a serial EEPROM and decides, cycle by cycle, whether a byte of the array or the status register itself may be written. A command decoder in front of it turns serial frames into single-cycle events: write-enable, write-disable, a status-write request that carries a data byte, and a frame-end pulse that marks chip-select going inactive. The array programmer behind it reports the internal write cycle on a busy input. The block drives three things: the status byte for readback, a permit for the array address currently presented, and a permit for status writes.

Two protection bits choose how much of the array is read-only: nothing, the top quarter, the top half or the whole array. A third bit arms the hardware protect pin. When that bit is set and the pin is low, status writes are refused. A fall of the pin during a frame also cancels a status write that has been requested but not yet committed. The protection bits model non-volatile storage. Only the power-on reset clears them. The command-level reset clears only the volatile state.

Top module: `eep_status_guard`

## Requirements
- R1: The status byte reads {armed-bit[7], 0[6:4], prot-select[3:2], enable-latch[1], ready[0]}. After a power-on reset it reads 0x00 while busy is low, and both permits are low.
- R2: A write-enable event sets the enable latch. A write-disable event clears it. When both arrive in the same cycle, the latch ends up cleared.
- R3: The enable latch clears in the cycle after busy falls, which marks the end of an internal write cycle.
- R4: The prot-select codes decode as follows: 00 protects no address, 01 protects 0x1800-0x1FFF, 10 protects 0x1000-0x1FFF, and 11 protects 0x0000-0x1FFF. A protected address never gets an array permit.
- R5: An address outside the protected range gets an array permit exactly when the enable latch is 1.
- R6: The status permit is high exactly when the enable latch is 1 and the armed bit and the low pin are not both present.
- R7: A status-write request is held until frame end. At frame end it commits only if the status permit is high in that cycle. A commit loads bits 7, 3 and 2 from the data byte and ignores its other bits.
- R8: While the armed bit is 1, a fall of the protect pin between request and frame end cancels the request, even if the pin is high again at frame end. While the armed bit is 0, the pin has no such effect. After a commit, pin changes leave the status bits unchanged.
- R9: While busy is high, write-enable, write-disable and status-write requests are all ignored.
- R10: The command reset clears the enable latch and any held request but keeps the armed bit and prot-select. The power-on reset clears everything.
- R11: The ready bit equals the busy input in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; clears all state |
| cmd_rst | input | 1 | Synchronous command reset; clears the volatile state only |
| busy | input | 1 | Internal write cycle in progress |
| wp | input | 1 | Hardware protect pin; low requests protection |
| wren | input | 1 | Write-enable event pulse |
| wrdi | input | 1 | Write-disable event pulse |
| wsr_req | input | 1 | Status-write request pulse |
| wsr_data | input | 8 | Data byte of the status-write request |
| frame_end | input | 1 | Chip-select deassertion pulse that ends a frame |
| addr | input | ADDR_W | Candidate array address |
| status | output | 8 | Status byte for readback |
| addr_wr_ok | output | 1 | The array address may be written |
| sr_wr_ok | output | 1 | The status register may be written |

## Verification
A wrong prot-select decode shows up immediately on addr_wr_ok for some address. For that reason the bench sweeps every address under every code, with the enable latch both set and clear. A held request or a missed pin fall that was lost or kept wrongly stays hidden until the next frame end, and then shows as a status byte that differs one cycle later. The bench therefore reads status right after every frame end. A enable latch that fails to clear after a write cycle shows in bit 1 one cycle after busy falls.

// File: rtl/eep_status_pkg.sv
package eep_status_pkg;
   typedef enum logic [1:0] {
      PROT_NONE = 2'b00,
      PROT_QTR  = 2'b01,
      PROT_HALF = 2'b10,
      PROT_ALL  = 2'b11
   } prot_sel_e;

   localparam int SR_W      = 8;
   localparam int SR_ARMED  = 7;
   localparam int SR_SEL_HI = 3;
   localparam int SR_SEL_LO = 2;
endpackage

// File: rtl/eep_prot_decode.sv
module eep_prot_decode
   import eep_status_pkg::*;
#(
   parameter int ADDR_W = 13
) (
   input  prot_sel_e           sel,
   input  logic [ADDR_W-1:0]   addr,
   output logic                hit
);
   localparam int TOP = ADDR_W - 1;

   if (ADDR_W < 2) begin : g_bad_width
      $error("eep_prot_decode: ADDR_W must be at least 2");
   end

   logic [1:0] upper;
   assign upper = addr[TOP -: 2];

   always_comb begin
      case (sel)
         PROT_NONE: hit = 1'b0;
         PROT_QTR:  hit = &upper;
         PROT_HALF: hit = upper[1];
         default:   hit = 1'b1;
      endcase
   end
endmodule

// File: rtl/eep_wel_latch.sv
module eep_wel_latch (
   input  logic clk,
   input  logic por_n,
   input  logic cmd_rst,
   input  logic busy,
   input  logic wren,
   input  logic wrdi,
   output logic wel
);
   logic busy_q;
   logic cycle_done;

   assign cycle_done = busy_q & ~busy;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         busy_q <= 1'b0;
         wel    <= 1'b0;
      end else begin
         busy_q <= busy;
         if (cmd_rst || cycle_done)
            wel <= 1'b0;
         else if (!busy) begin
            if (wrdi)
               wel <= 1'b0;
            else if (wren)
               wel <= 1'b1;
         end
      end
   end

   // R3: the end of an internal cycle leaves the latch cleared
   a_r3_done_clears: assert property (@(posedge clk) disable iff (!por_n)
      (busy_q && !busy) |=> !wel);
   // R9: no set while busy
   a_r9_busy_no_set: assert property (@(posedge clk) disable iff (!por_n)
      (busy && !wel) |=> !wel);
   // R2: disable wins over enable
   a_r2_disable_wins: assert property (@(posedge clk) disable iff (!por_n)
      (wrdi && !busy) |=> !wel);
endmodule

// File: rtl/eep_sr_bits.sv
module eep_sr_bits
   import eep_status_pkg::*;
(
   input  logic            clk,
   input  logic            por_n,
   input  logic            cmd_rst,
   input  logic            busy,
   input  logic            wp,
   input  logic            wsr_req,
   input  logic            req_armed,
   input  logic [1:0]      req_sel,
   input  logic            frame_end,
   input  logic            wel,
   output logic            armed,
   output prot_sel_e       sel,
   output logic            sr_ok
);
   logic       wp_q;
   logic       wp_fall;
   logic       pend;
   logic       pend_armed;
   logic [1:0] pend_sel;
   logic       commit;

   assign sr_ok   = wel & ~(armed & ~wp);
   assign wp_fall = wp_q & ~wp;
   assign commit  = frame_end & pend & sr_ok & ~cmd_rst;

   // volatile request holder
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         wp_q       <= 1'b0;
         pend       <= 1'b0;
         pend_armed <= 1'b0;
         pend_sel   <= 2'b00;
      end else begin
         wp_q <= wp;
         if (cmd_rst || frame_end)
            pend <= 1'b0;
         else if (pend && armed && wp_fall)
            pend <= 1'b0;
         else if (wsr_req && !busy) begin
            pend       <= 1'b1;
            pend_armed <= req_armed;
            pend_sel   <= req_sel;
         end
      end
   end

   // retained bits: only power-on reset clears them
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         armed <= 1'b0;
         sel   <= PROT_NONE;
      end else if (commit) begin
         armed <= pend_armed;
         sel   <= prot_sel_e'(pend_sel);
      end
   end

   // R7: retained bits move only at a frame end
   a_r7_hold_between_frames: assert property (@(posedge clk) disable iff (!por_n)
      !frame_end |=> $stable({armed, sel}));
   // R6: a refused frame end changes nothing
   a_r6_refused_keeps: assert property (@(posedge clk) disable iff (!por_n)
      (frame_end && !sr_ok) |=> $stable({armed, sel}));
   // R9: no request is taken while busy
   a_r9_no_req_when_busy: assert property (@(posedge clk) disable iff (!por_n)
      (busy && !pend) |=> !pend);
   // R10: command reset drops a held request
   a_r10_cmd_rst_drops: assert property (@(posedge clk) disable iff (!por_n)
      cmd_rst |=> !pend);
endmodule

// File: rtl/eep_status_guard.sv
module eep_status_guard
   import eep_status_pkg::*;
#(
   parameter int ADDR_W = 13
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic               cmd_rst,
   input  logic               busy,
   input  logic               wp,
   input  logic               wren,
   input  logic               wrdi,
   input  logic               wsr_req,
   input  logic [7:0]         wsr_data,
   input  logic               frame_end,
   input  logic [ADDR_W-1:0]  addr,
   output logic [7:0]         status,
   output logic               addr_wr_ok,
   output logic               sr_wr_ok
);
   if (SR_W != 8) begin : g_bad_sr
      $error("eep_status_guard: status width must be 8");
   end

   logic      wel;
   logic      armed;
   prot_sel_e sel;
   logic      hit;
   logic      unused_data;

   assign unused_data = ^{wsr_data[6:4], wsr_data[1:0]};

   eep_wel_latch u_wel (
      .clk     (clk),
      .por_n   (por_n),
      .cmd_rst (cmd_rst),
      .busy    (busy),
      .wren    (wren),
      .wrdi    (wrdi),
      .wel     (wel)
   );

   eep_sr_bits u_sr (
      .clk       (clk),
      .por_n     (por_n),
      .cmd_rst   (cmd_rst),
      .busy      (busy),
      .wp        (wp),
      .wsr_req   (wsr_req),
      .req_armed (wsr_data[SR_ARMED]),
      .req_sel   (wsr_data[SR_SEL_HI:SR_SEL_LO]),
      .frame_end (frame_end),
      .wel       (wel),
      .armed     (armed),
      .sel       (sel),
      .sr_ok     (sr_wr_ok)
   );

   eep_prot_decode #(.ADDR_W(ADDR_W)) u_dec (
      .sel  (sel),
      .addr (addr),
      .hit  (hit)
   );

   assign addr_wr_ok = wel & ~hit;
   assign status     = {armed, 3'b000, sel, wel, busy};

   // R4: full protection blocks every address
   a_r4_full_blocks: assert property (@(posedge clk) disable iff (!por_n)
      (status[3:2] == 2'b11) |-> !addr_wr_ok);
   // R5: no enable latch, no array permit
   a_r5_needs_latch: assert property (@(posedge clk) disable iff (!por_n)
      !status[1] |-> !addr_wr_ok);
   // R1: reserved bits read zero
   a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!por_n)
      status[6:4] == 3'b000);
endmodule

// File: tb/eep_status_guard_tb.sv
module eep_status_guard_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW         = 13;
   localparam int DEPTH      = 1 << AW;

   logic          clk = 1'b0;
   logic          por_n, cmd_rst, busy, wp, wren, wrdi, wsr_req, frame_end;
   logic [7:0]    wsr_data;
   logic [AW-1:0] addr;
   logic [7:0]    status;
   logic          addr_wr_ok, sr_wr_ok;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   eep_status_guard #(.ADDR_W(AW)) u_dut (
      .clk(clk), .por_n(por_n), .cmd_rst(cmd_rst), .busy(busy), .wp(wp),
      .wren(wren), .wrdi(wrdi), .wsr_req(wsr_req), .wsr_data(wsr_data),
      .frame_end(frame_end), .addr(addr), .status(status),
      .addr_wr_ok(addr_wr_ok), .sr_wr_ok(sr_wr_ok)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic do_wren();  wren = 1'b1; tick(); wren = 1'b0; endtask
   task automatic do_wrdi();  wrdi = 1'b1; tick(); wrdi = 1'b0; endtask
   task automatic do_end();   frame_end = 1'b1; tick(); frame_end = 1'b0; endtask
   task automatic do_wsr(input logic [7:0] d);
      wsr_req = 1'b1; wsr_data = d; tick(); wsr_req = 1'b0;
   endtask
   task automatic busy_pulse();
      busy = 1'b1; tick(); tick(); busy = 1'b0; tick();
   endtask
   task automatic set_sr(input logic [7:0] d);
      do_wren(); do_wsr(d); do_end(); busy_pulse();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      por_n = 1'b0; cmd_rst = 1'b0; busy = 1'b0; wp = 1'b1; wren = 1'b0;
      wrdi = 1'b0; wsr_req = 1'b0; wsr_data = 8'h00; frame_end = 1'b0;
      addr = '0;
      tick(); tick();
      por_n = 1'b1;
      tick();
      chk("R1 reset status", status, 8'h00);
      chk("R1 reset sr permit", sr_wr_ok, 1'b0);
      chk("R1 reset addr permit", addr_wr_ok, 1'b0);

      // R2 enable / disable
      do_wren();
      chk("R2 wren sets", status, 8'h02);
      do_wrdi();
      chk("R2 wrdi clears", status, 8'h00);
      do_wren();
      wren = 1'b1; wrdi = 1'b1; tick(); wren = 1'b0; wrdi = 1'b0;
      chk("R2 both clears", status, 8'h00);

      // R11 ready mirrors busy, R9 commands ignored while busy
      do_wren();
      busy = 1'b1; #1;
      chk("R11 ready follows busy", status, 8'h03);
      tick();
      do_wrdi();
      chk("R9 wrdi ignored while busy", status, 8'h03);
      do_wsr(8'h0C);
      busy = 1'b0; tick();
      chk("R3 latch cleared at cycle end", status, 8'h00);
      chk("R11 ready low", status[0], 1'b0);
      do_wren(); do_end();
      chk("R9 request while busy not held", status, 8'h02);
      busy = 1'b1; tick(); busy = 1'b0; tick();
      busy = 1'b1; tick(); do_wren(); busy = 1'b0; tick();
      chk("R9 wren ignored while busy", status, 8'h00);

      // R6 / R7 sweep over armed bit, pin and latch
      for (int ai = 0; ai < 2; ai++) begin
         for (int pi = 0; pi < 2; pi++) begin
            for (int li = 0; li < 2; li++) begin
               logic exp_ok;
               logic [7:0] exp_st;
               wp = 1'b1;
               set_sr({ai[0], 7'h00});
               chk("R7 armed setup", status, {ai[0], 7'h00});
               wp = pi[0]; tick();
               if (li != 0) do_wren();
               exp_ok = li[0] & ~(ai[0] & ~pi[0]);
               chk("R6 status permit", sr_wr_ok, exp_ok);
               do_wsr({ai[0], 7'h7F});
               do_end();
               exp_st = {ai[0], 3'b000, exp_ok ? 2'b11 : 2'b00, li[0], 1'b0};
               chk("R7 commit result", status, exp_st);
               busy_pulse();
            end
         end
      end

      // R7 ignored data bits
      wp = 1'b1;
      set_sr(8'h00);
      do_wren(); do_wsr(8'h71); do_end();
      chk("R7 other bits ignored", status, 8'h02);
      busy_pulse();

      // R8 cancel by pin fall while armed
      set_sr(8'h80);
      do_wren(); do_wsr(8'h8C);
      wp = 1'b0; tick(); wp = 1'b1; tick();
      do_end();
      chk("R8 pin fall cancels", status, 8'h82);
      do_wsr(8'h8C); do_end();
      chk("R8 clean frame commits", status, 8'h8E);
      wp = 1'b0; tick(); tick();
      chk("R8 pin after commit", status, 8'h8E);
      wp = 1'b1; tick();
      busy_pulse();
      chk("R3 latch cleared after status cycle", status, 8'h8C);
      set_sr(8'h00);
      do_wren(); do_wsr(8'h08);
      wp = 1'b0; tick(); wp = 1'b1; tick();
      do_end();
      chk("R8 pin ignored when not armed", status, 8'h0A);
      busy_pulse();

      // R10 resets
      set_sr(8'h8C);
      do_wren();
      cmd_rst = 1'b1; tick(); cmd_rst = 1'b0;
      chk("R10 cmd reset keeps retained bits", status, 8'h8C);
      do_wren(); do_wsr(8'h00);
      cmd_rst = 1'b1; tick(); cmd_rst = 1'b0;
      do_wren(); do_end();
      chk("R10 cmd reset drops request", status, 8'h8E);
      por_n = 1'b0; tick(); por_n = 1'b1; tick();
      chk("R10 power-on clears all", status, 8'h00);

      // R4 / R5 address sweep for every select code
      for (int s = 0; s < 4; s++) begin
         set_sr({4'h0, s[1:0], 2'b00});
         for (int li = 0; li < 2; li++) begin
            if (li != 0) do_wren();
            for (int a = 0; a < DEPTH; a++) begin
               logic prot;
               addr = a[AW-1:0];
               #1;
               prot = (s == 3) || (s == 2 && a >= DEPTH/2) ||
                      (s == 1 && a >= (3*DEPTH)/4);
               chk(prot ? "R4 protected address" : "R5 unprotected address",
                   addr_wr_ok, li[0] & ~prot);
            end
            if (li != 0) do_wrdi();
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule